// File: doc/BRIEF.md
# Pulse-Stream Level Decoder with Idle Watchdog

This block sits on the receive side of an edge-encoded link. The far end does not send a level. It sends short "go high" and "go low" pulses on two separate lines. The decoder turns these back into a steady logic level by keeping a bistable state: a high-pulse sets it, a low-pulse clears it, and it holds its value while no pulse arrives. A healthy transmitter repeats the current level at intervals well below the watchdog limit, so the rebuilt level stays correct even when the data does not change for a long time.

An idle watchdog counts clock cycles since the last pulse on either line. If the count reaches a programmable number of cycles, the decoder treats the far end as unpowered or broken. It then drives its output to the default high level and raises a status flag. The first pulse that arrives afterwards clears the flag, and its value shows on the output at the same clock edge. If both pulse lines are active in the same cycle, the decoder keeps its stored level and reports a protocol error for one cycle.

The asynchronous active-low reset is released synchronously inside the block. All outputs are registered state, or a gate on registered state.

Top module: `pulse_decoder`

## Requirements
- R1: During reset and at the first active edge after it, level_o is 1, wd_expired_o is 0 and proto_err_o is 0. The idle count starts from zero, so with no pulses wd_expired_o rises exactly at the TIMEOUT_CYC-th active edge after reset release.
- R2: A cycle with set_pulse_i=1 and clr_pulse_i=0 makes level_o 1 from the next edge on.
- R3: A cycle with clr_pulse_i=1 and set_pulse_i=0 makes level_o 0 from the next edge on.
- R4: While both pulse inputs are 0 and the watchdog has not expired, level_o keeps its value.
- R5: When both pulse inputs are 1 in the same cycle, level_o keeps its previous value and proto_err_o is 1 for exactly the following cycle. The conflicting cycle still counts as a pulse for the watchdog.
- R6: After TIMEOUT_CYC consecutive cycles with both pulse inputs at 0, wd_expired_o is 1 and level_o is 1.
- R7: Any pulse clears wd_expired_o at the next edge, and the value that pulse carries appears on level_o at that same edge.
- R8: Watchdog expiry also presets the stored level to high, so a conflicting pair that ends an expiry leaves level_o at 1.
- R9: Same-valued refresh pulses spaced by fewer than TIMEOUT_CYC idle cycles keep level_o steady and never set wd_expired_o.
- R10: The idle count saturates, so arbitrarily long silence keeps wd_expired_o at 1, and recovery still takes one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_pulse_i | input | 1 | "Go high" pulse from the link |
| clr_pulse_i | input | 1 | "Go low" pulse from the link |
| level_o | output | 1 | Rebuilt logic level, forced high on watchdog expiry |
| wd_expired_o | output | 1 | High while no pulse has arrived for TIMEOUT_CYC cycles |
| proto_err_o | output | 1 | One-cycle flag after both pulse lines were active together |

## Verification
The assertions assume that both pulse inputs are already synchronous to clk and settle well before each edge, and that one clock cycle with an input high counts as one pulse. They do not assume that pulses are isolated or spaced in any particular way. They only hold once the internally synchronized reset has been released. The bench drives the inputs only at falling edges and holds each value for one full cycle. It walks every input combination from each stored state: low, high and expired. It also sweeps every idle gap up to and past the timeout, which covers both the refresh spacing and the overlap of conflicts with expiry.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic [1:0] {
    PK_IDLE = 2'b00,
    PK_SET  = 2'b01,
    PK_CLR  = 2'b10,
    PK_BOTH = 2'b11
  } pulse_kind_e;

  function automatic pulse_kind_e classify(input logic set_b, input logic clr_b);
    logic [1:0] raw;
    raw = {clr_b, set_b};
    return pulse_kind_e'(raw);
  endfunction

endpackage

// File: rtl/pdec_rst_sync.sv
module pdec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign srst_n = arst_n;
    end else if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= {q[STAGES-2:0], 1'b1};
      end
      assign srst_n = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pdec_classify.sv
module pdec_classify
  import pdec_pkg::*;
(
  input  logic        set_i,
  input  logic        clr_i,
  output pulse_kind_e kind_o,
  output logic        any_o
);

  always_comb begin
    kind_o = classify(set_i, clr_i);
    any_o  = (kind_o != PK_IDLE);
  end

endmodule

// File: rtl/pdec_wdog.sv
module pdec_wdog #(
  parameter int unsigned TIMEOUT_CYC = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pulse_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = any_pulse_i || (cnt_q != LIMIT);
    if (any_pulse_i)          cnt_d = '0;
    else if (cnt_q != LIMIT)  cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
    exp_d = !any_pulse_i && (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

endmodule

// File: rtl/pdec_latch.sv
module pdec_latch
  import pdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pulse_kind_e kind_i,
  input  logic        expired_i,
  output logic        stored_o,
  output logic        conflict_o
);

  logic lvl_q, lvl_d;
  logic err_q, err_d;
  logic lvl_en;

  always_comb begin
    lvl_d = lvl_q;
    err_d = 1'b0;
    unique case (kind_i)
      PK_SET:  lvl_d = 1'b1;
      PK_CLR:  lvl_d = 1'b0;
      PK_BOTH: begin
        err_d = 1'b1;
        if (expired_i) lvl_d = 1'b1;
      end
      default: if (expired_i) lvl_d = 1'b1;
    endcase
    lvl_en = (lvl_d != lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      if (lvl_en) lvl_q <= lvl_d;
      err_q <= err_d;
    end
  end

  assign stored_o   = lvl_q;
  assign conflict_o = err_q;

endmodule

// File: rtl/pulse_decoder.sv
module pulse_decoder
  import pdec_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 625,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse_i,
  input  logic clr_pulse_i,
  output logic level_o,
  output logic wd_expired_o,
  output logic proto_err_o
);

  logic        rst_sync_n;
  pulse_kind_e kind;
  logic        any_pulse;
  logic        expired;
  logic        stored;

  pdec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pdec_classify u_cls (
    .set_i  (set_pulse_i),
    .clr_i  (clr_pulse_i),
    .kind_o (kind),
    .any_o  (any_pulse)
  );

  pdec_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .any_pulse_i (any_pulse),
    .expired_o   (expired)
  );

  pdec_latch u_lat (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .kind_i     (kind),
    .expired_i  (expired),
    .stored_o   (stored),
    .conflict_o (proto_err_o)
  );

  assign level_o      = stored | expired;
  assign wd_expired_o = expired;

endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int unsigned TIMEOUT_CYC = 625
) (
  input logic clk,
  input logic rst_n,
  input logic set_i,
  input logic clr_i,
  input logic level_o,
  input logic wd_expired_o,
  input logic proto_err_o
);

  localparam int unsigned IW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [IW-1:0] ILIM = IW'(TIMEOUT_CYC);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_q <= '0;
    else if (set_i || clr_i) idle_q <= '0;
    else if (idle_q != ILIM) idle_q <= idle_q + 1'b1;
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> level_o);  // R2

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !level_o);  // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && (idle_q < ILIM - 1'b1)) |=> $stable(level_o));  // R4

  AST_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> (proto_err_o && level_o == $past(level_o)));  // R5

  AST_ERR_ONLY_AFTER_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> $past(set_i && clr_i));  // R5

  AST_EXPIRY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired_o == (idle_q == ILIM));  // R6

  AST_EXPIRED_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired_o |-> level_o);  // R6

  AST_PULSE_CLEARS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i || clr_i) |=> !wd_expired_o);  // R7

  AST_EXPIRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expired_o && !set_i && !clr_i) |=> wd_expired_o);  // R10

endmodule

bind pulse_decoder pdec_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .set_i        (set_pulse_i),
  .clr_i        (clr_pulse_i),
  .level_o      (level_o),
  .wd_expired_o (wd_expired_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/pulse_decoder_tb_top.sv
`timescale 1ns/1ps
module pulse_decoder_tb_top;

  localparam int unsigned T = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic set_p, clr_p;
  logic level, expd, perr;

  int checks = 0;
  int errors = 0;

  // reference state built from the requirements
  logic m_lat, m_exp, m_err;
  int   m_idle;

  always #4 clk = ~clk;

  pulse_decoder #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_pulse_i  (set_p),
    .clr_pulse_i  (clr_p),
    .level_o      (level),
    .wd_expired_o (expd),
    .proto_err_o  (perr)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string tag);
    chk(tag, "level_o", level, m_exp | m_lat);
    chk(tag, "wd_expired_o", expd, m_exp);
    chk(tag, "proto_err_o", perr, m_err);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic s, input logic c);
    string tag;
    tag = (s && c) ? "R5" : s ? "R2" : c ? "R3" : m_exp ? "R10" : "R4";
    set_p = s;
    clr_p = c;
    @(posedge clk);
    if (s && !c)       m_lat = 1'b1;
    else if (c && !s)  m_lat = 1'b0;
    else if (m_exp)    m_lat = 1'b1;
    m_err = s & c;
    if (s || c) begin
      m_idle = 0;
      m_exp  = 1'b0;
    end else begin
      if (m_idle < T) m_idle++;
      m_exp = (m_idle >= T);
    end
    @(negedge clk);
    if (!m_exp && m_idle == T - 1 && !(s || c)) tag = "R6";
    chk_model(tag);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_p = 1'b1;
    clr_p = 1'b0;
    m_lat = 1'b1; m_exp = 1'b0; m_err = 1'b0; m_idle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values even with a pulse present
    chk("R1", "level_o in reset", level, 1'b1);
    chk("R1", "wd_expired_o in reset", expd, 1'b0);
    chk("R1", "proto_err_o in reset", perr, 1'b0);
    set_p = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "level_o after release", level, 1'b1);
    chk("R1", "wd_expired_o after release", expd, 1'b0);

    // R1, R6: expiry exactly at the T-th idle edge after release
    idle_n(T - 1);
    chk("R1", "no expiry at T-1", expd, 1'b0);
    step(1'b0, 1'b0);
    chk("R6", "expiry at T", expd, 1'b1);
    chk("R6", "forced high", level, 1'b1);

    // R7: a clear pulse during expiry shows at once
    step(1'b0, 1'b1);
    chk("R7", "expiry cleared", expd, 1'b0);
    chk("R7", "level follows clr", level, 1'b0);

    // R8: store low, let it expire, then a conflicting pair
    idle_n(T);
    chk("R8", "expired", expd, 1'b1);
    step(1'b1, 1'b1);
    chk("R8", "level high after conflict", level, 1'b1);
    chk("R8", "err flag", perr, 1'b1);
    chk("R8", "expiry cleared", expd, 1'b0);
    step(1'b0, 1'b0);
    chk("R5", "err one cycle", perr, 1'b0);

    // R9: refresh of a low level at the longest legal spacing
    step(1'b0, 1'b1);
    for (int k = 0; k < 20; k++) begin
      idle_n(T - 1);
      chk("R9", "no expiry between refreshes", expd, 1'b0);
      chk("R9", "level steady", level, 1'b0);
      step(1'b0, 1'b1);
    end

    // R10: long silence, then one-edge recovery
    idle_n(5 * T);
    chk("R10", "still expired", expd, 1'b1);
    step(1'b1, 1'b0);
    chk("R10", "recovered", expd, 1'b0);
    chk("R2", "level high", level, 1'b1);

    // sweep: each starting state x each input pair x each idle gap
    for (int st = 0; st < 3; st++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int gap = 0; gap <= T + 2; gap++) begin
          if (st == 0)      step(1'b0, 1'b1);
          else if (st == 1) step(1'b1, 1'b0);
          else              idle_n(T);
          step(pat[0], pat[1]);
          idle_n(gap);
          step(pat[1], pat[0]);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule